// File: doc/BRIEF.md
# Shadowed Read Wrapper for a Single-Register Core

This block sits between a system bus and a small core that owns one internal register. A bus master reads that register at one fixed address using a four-phase request/acknowledge handshake: the master raises its request, the wrapper raises acknowledge with valid data, the master drops its request, and the wrapper then drops acknowledge. The wrapper does not talk to the register directly. It reaches it through a second, separate four-phase handshake with the core internals.

If each bus read were forwarded through the inner handshake, the wrapper would add several cycles of read latency. Instead, a refresh engine runs the inner handshake without pause and keeps a shadow copy of the core register. Bus reads are answered from that copy, or from the word being captured on the same edge. The bus therefore sees one-cycle acknowledge latency. The price is that the data may be up to four cycles old.

Top module: `shadow_rd_wrapper`

## Requirements
- R1: While reset is high, and on the first clock after it, `bus_ack`, `bus_drive` and `core_req` are low and `bus_rdata` is all zeros.
- R2: The wrapper drops `core_req` on the edge after it samples `core_req` and `core_ack` both high. It raises `core_req` on the edge after it samples both low, so a new inner transaction starts right away. A core that follows `core_req` with `core_ack` after one cycle therefore completes a transaction, and refreshes the shadow, every four cycles.
- R3: The shadow copy takes the value on `core_data` on each edge where `core_req` and `core_ack` are both high.
- R4: When `core_ack` follows `core_req` after one cycle, the data returned when `bus_ack` rises equals a value the core register held during that cycle or one of the four cycles before it.
- R5: When the shadow is valid, a request with `bus_addr` equal to `REG_ADDR` that is seen while `bus_ack` is low raises `bus_ack` on the next edge.
- R6: A request whose address differs from `REG_ADDR` gets no acknowledge for as long as it is held. During that time `bus_drive` stays low and `bus_rdata` stays all zeros.
- R7: `bus_drive` equals `bus_ack`. `bus_rdata` is all zeros while `bus_ack` is low. The data is held unchanged while `bus_ack` stays high. `bus_ack` falls on the edge after `bus_req` is sampled low.
- R8: After reset the shadow is invalid, and a matching request waits. `bus_ack` rises on the same edge as the first inner capture, and the data returned is the word captured on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus read request |
| bus_addr | input | ADDR_W | Bus read address |
| bus_ack | output | 1 | Bus acknowledge, data valid while high |
| bus_drive | output | 1 | High while the wrapper drives the data bus |
| bus_rdata | output | DATA_W | Bus read data, zero when not driven |
| core_req | output | 1 | Inner fetch request to the core |
| core_ack | input | 1 | Inner fetch acknowledge from the core |
| core_data | input | DATA_W | Core register value, valid while core_ack is high |

## Verification
The bench models a core register that changes on every clock. This means any read path that is one cycle too slow returns a value outside the allowed window, and the age check reports it. Reads are placed at every phase of the four-cycle refresh. This covers the read whose acknowledge lands on a capture edge, where a design without the capture bypass would return data five cycles old. A read that is already waiting when reset is released exercises the invalid-shadow stall: a design that acknowledged early would return the reset value of the shadow. Held misaddressed requests check that no acknowledge or data escapes. Long request holds check that the data does not change when a refresh occurs during an acknowledge.

// File: rtl/shwr_pkg.sv
package shwr_pkg;

    localparam int DEF_DATA_W  = 16;
    localparam int DEF_ADDR_W  = 8;
    localparam int DEF_MAX_AGE = 4;

    typedef enum logic {
        RF_WAIT_HI = 1'b0,
        RF_WAIT_LO = 1'b1
    } refresh_st_e;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_ACK  = 1'b1
    } bus_st_e;

    function automatic logic both_high(input logic a, input logic b);
        return a & b;
    endfunction

endpackage

// File: rtl/shwr_refresh.sv
module shwr_refresh
    import shwr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic              core_req,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_data,
    output logic [DATA_W-1:0] shadow_q,
    output logic              shadow_valid,
    output logic              fetch_done
);

    refresh_st_e st_q;

    assign core_req   = (st_q == RF_WAIT_HI);
    assign fetch_done = both_high(core_req, core_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= RF_WAIT_LO;
            shadow_q     <= '0;
            shadow_valid <= 1'b0;
        end else begin
            case (st_q)
                RF_WAIT_HI: begin
                    if (core_ack) begin
                        shadow_q     <= core_data;
                        shadow_valid <= 1'b1;
                        st_q         <= RF_WAIT_LO;
                    end
                end
                RF_WAIT_LO: begin
                    if (!core_ack) st_q <= RF_WAIT_HI;
                end
                default: st_q <= RF_WAIT_LO;
            endcase
        end
    end

endmodule

// File: rtl/shwr_bus_side.sv
module shwr_bus_side
    import shwr_pkg::*;
#(
    parameter int          DATA_W   = DEF_DATA_W,
    parameter int          ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ack,
    output logic              bus_drive,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] shadow_q,
    input  logic              shadow_valid,
    input  logic              fetch_done,
    input  logic [DATA_W-1:0] fetch_data
);

    bus_st_e           st_q;
    logic [DATA_W-1:0] hold_q;
    logic              hit;
    logic              data_ready;
    logic [DATA_W-1:0] pick;

    assign hit        = bus_req && (bus_addr == REG_ADDR);
    assign data_ready = shadow_valid || fetch_done;
    assign pick       = fetch_done ? fetch_data : shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BS_IDLE;
            hold_q <= '0;
        end else begin
            case (st_q)
                BS_IDLE: begin
                    if (hit && data_ready) begin
                        hold_q <= pick;
                        st_q   <= BS_ACK;
                    end
                end
                BS_ACK: begin
                    if (!bus_req) st_q <= BS_IDLE;
                end
                default: st_q <= BS_IDLE;
            endcase
        end
    end

    assign bus_ack   = (st_q == BS_ACK);
    assign bus_drive = bus_ack;
    assign bus_rdata = bus_ack ? hold_q : '0;

endmodule

// File: rtl/shadow_rd_wrapper.sv
module shadow_rd_wrapper
    import shwr_pkg::*;
#(
    parameter int          DATA_W   = DEF_DATA_W,
    parameter int          ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ack,
    output logic              bus_drive,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_req,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_data
);

    logic [DATA_W-1:0] shadow_q;
    logic              shadow_valid;
    logic              fetch_done;

    shwr_refresh #(.DATA_W(DATA_W)) u_refresh (
        .clk          (clk),
        .rst          (rst),
        .core_req     (core_req),
        .core_ack     (core_ack),
        .core_data    (core_data),
        .shadow_q     (shadow_q),
        .shadow_valid (shadow_valid),
        .fetch_done   (fetch_done)
    );

    shwr_bus_side #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_bus (
        .clk          (clk),
        .rst          (rst),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr),
        .bus_ack      (bus_ack),
        .bus_drive    (bus_drive),
        .bus_rdata    (bus_rdata),
        .shadow_q     (shadow_q),
        .shadow_valid (shadow_valid),
        .fetch_done   (fetch_done),
        .fetch_data   (core_data)
    );

endmodule

// File: rtl/shwr_checker.sv
module shwr_checker #(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int          MAX_AGE  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_drive,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_req,
    input logic              core_ack,
    input logic              shadow_valid
);

    localparam int CW = $clog2(MAX_AGE + 2);
    logic [CW-1:0] age_cnt;

    always_ff @(posedge clk) begin
        if (rst) age_cnt <= '0;
        else if (core_req && core_ack) age_cnt <= '0;
        else if (age_cnt != CW'(MAX_AGE + 1)) age_cnt <= age_cnt + 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!bus_ack && !core_req && !bus_drive));

    a_r2_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        (core_req && core_ack) |=> !core_req);

    a_r2_refresh_period: assert property (@(posedge clk) disable iff (rst)
        shadow_valid |-> (age_cnt < CW'(MAX_AGE)));

    a_r5_one_cycle_ack: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack && bus_req && bus_addr == REG_ADDR && shadow_valid) |=> bus_ack);

    a_r6_miss_no_ack: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack && bus_req && bus_addr != REG_ADDR) |=> !bus_ack);

    a_r7_data_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_ack)) |-> $stable(bus_rdata));

    a_r7_ack_release: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_req) |=> !bus_ack);

    a_r7_drive_tracks_ack: assert property (@(posedge clk) disable iff (rst)
        bus_drive == bus_ack);

    a_r8_no_ack_before_valid: assert property (@(posedge clk) disable iff (rst)
        (!shadow_valid && !$past(shadow_valid)) |-> !bus_ack);

endmodule

bind shadow_rd_wrapper shwr_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .MAX_AGE  (shwr_pkg::DEF_MAX_AGE)
) u_shwr_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .bus_ack      (bus_ack),
    .bus_drive    (bus_drive),
    .bus_rdata    (bus_rdata),
    .core_req     (core_req),
    .core_ack     (core_ack),
    .shadow_valid (shadow_valid)
);

// File: tb/test_shadow_rd_wrapper.sv
`timescale 1ns/1ps
module test_shadow_rd_wrapper;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam logic [AW-1:0] RADDR = 8'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_ack, bus_drive, core_req;
    logic [DW-1:0] bus_rdata;
    logic          core_ack = 1'b0;
    logic [DW-1:0] core_data;
    logic [31:0]   cyc = 0;

    int total = 0;
    int bad = 0;
    string phase_tag = "R1";

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] core_val(input logic [31:0] n);
        return DW'(n * 32'd37 + 32'd5);
    endfunction

    assign core_data = core_val(cyc);

    shadow_rd_wrapper #(.DATA_W(DW), .ADDR_W(AW), .REG_ADDR(RADDR)) i_shadow_rd_wrapper (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_drive(bus_drive), .bus_rdata(bus_rdata),
        .core_req(core_req), .core_ack(core_ack), .core_data(core_data)
    );

    // core model: register changes each cycle, ack follows req by one cycle
    always @(posedge clk) begin
        cyc <= cyc + 1;
        core_ack <= rst ? 1'b0 : core_req;
    end

    // behavioural reference model
    logic          m_req = 0, m_ack = 0, m_valid = 0;
    logic [DW-1:0] m_shadow = '0, m_rdata = '0;
    always @(posedge clk) begin
        logic cap, nack;
        if (rst) begin
            m_req = 0; m_ack = 0; m_valid = 0; m_shadow = '0; m_rdata = '0;
        end else begin
            cap = m_req && core_ack;
            if (m_ack) nack = bus_req;
            else       nack = bus_req && (bus_addr == RADDR) && (m_valid || cap);
            if (!m_ack && nack) m_rdata = cap ? core_data : m_shadow;
            if (cap) begin m_shadow = core_data; m_valid = 1; end
            if (m_req && core_ack)        m_req = 0;
            else if (!m_req && !core_ack) m_req = 1;
            m_ack = nack;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // compare every cycle, away from the active edge
    logic prev_ack = 0;
    always @(negedge clk) begin
        string t;
        t = rst ? "R1" : phase_tag;
        chk(core_req == m_req, rst ? "R1" : "R2 core_req", 32'(core_req), 32'(m_req));
        chk(bus_ack == m_ack, t, 32'(bus_ack), 32'(m_ack));
        chk(bus_drive == m_ack, "R7 drive", 32'(bus_drive), 32'(m_ack));
        chk(bus_rdata == (m_ack ? m_rdata : '0), rst ? "R1" : "R7/R3 data",
            32'(bus_rdata), 32'(m_ack ? m_rdata : '0));
        if (!rst && bus_ack && !prev_ack) begin
            bit in_win;
            in_win = 0;
            for (int k = 0; k <= 4; k++)
                if (bus_rdata == core_val(cyc - 32'(k))) in_win = 1;
            chk(in_win, "R4 age window", 32'(bus_rdata), 32'(core_val(cyc)));
        end
        prev_ack = bus_ack;
    end

    task automatic do_read(input logic [AW-1:0] a, input int hold, input int limit);
        @(negedge clk);
        bus_addr = a;
        bus_req  = 1'b1;
        for (int i = 0; i < limit && !bus_ack; i++) @(negedge clk);
        repeat (hold) @(negedge clk);
        bus_req = 1'b0;
        for (int i = 0; i < 4 && bus_ack; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state; R8 read pending across reset release
        phase_tag = "R8";
        bus_addr = RADDR;
        bus_req  = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 10 && !bus_ack; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        bus_req = 1'b0;
        repeat (3) @(negedge clk);

        // R5/R4/R7: reads landing on every refresh phase, varied hold
        phase_tag = "R5";
        for (int i = 0; i < 16; i++) begin
            repeat (i % 5) @(negedge clk);
            do_read(RADDR, i % 4, 8);
        end

        // R6: misaddressed requests held long
        phase_tag = "R6";
        for (int i = 1; i <= 4; i++) begin
            do_read(RADDR ^ AW'(i), 0, 8);
            repeat (2) @(negedge clk);
        end

        // R7: long hold spanning several refreshes
        phase_tag = "R7";
        do_read(RADDR, 9, 8);

        // R8 again after a mid-run reset
        phase_tag = "R8";
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_read(RADDR, 1, 10);
        phase_tag = "R5";
        do_read(RADDR, 0, 8);
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule